// File: doc/BRIEF.md
# Debug trace nibble serializer

This block sits beside a processor core and turns debug trace events into a stream of 4-bit values, one value per clock. There are two kinds of event. An operand event carries a direction flag (read or write), an access size and up to 32 bits of data. A taken-branch event carries a 32-bit target address. Two 2-bit control inputs set the filtering. One selects which operand directions are captured. The other selects how many low-order bytes of a branch target are sent. Both controls are sampled on the cycle an event is accepted.

Events enter through a valid/ready handshake, and the block holds one event at a time. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. The source must keep `ev_valid` and its payload stable until that edge. While the block is sending nibbles it holds `ev_ready` low, and any event offered in that time waits. There is no back-pressure on the trace output: each nibble is present for exactly one cycle, marked by `trc_valid`. Reset is synchronous and active high.

Top module: `trace_nibble_serializer`

## Requirements
- R1: For an operand event (`ev_kind`=0), `capture_mode` selects capture as follows: 00 captures nothing, 01 captures only writes (`ev_write`=1), 10 captures only reads (`ev_write`=0), and 11 captures both.
- R2: A captured operand sends a number of nibbles set by its access size: `ev_size` 00 (byte) sends 2, 01 (word) sends 4, 10 (long) sends 8, and the reserved code 11 is treated as long.
- R3: An event that is filtered out or has zero length is accepted in a single cycle. It produces no nibble, and `ev_ready` is high again on the next cycle.
- R4: For a branch event (`ev_kind`=1), `target_mode` sets how many address bytes are sent: 00 sends none, 01 sends the low 2 bytes (4 nibbles), 10 sends the low 3 bytes (6 nibbles), and 11 sends all 4 bytes (8 nibbles).
- R5: Nibbles are sent least significant first, one per clock. The first nibble appears in the cycle after acceptance.
- R6: `ev_ready` is low during every cycle that carries a nibble and goes high in the cycle after the last nibble. An event offered while a stream is in progress is not accepted and does not change that stream.
- R7: `trc_valid` is high exactly in the cycles that carry a nibble. While `trc_valid` is low, `trc_nibble` reads zero.
- R8: Synchronous reset drops any partly sent event. In the cycle after reset, `trc_valid` is low and `ev_ready` is high.
- R9: `capture_mode` and `target_mode` take effect only when an event is accepted. Changing them during a stream does not change that stream's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| capture_mode | input | 2 | Operand direction filter |
| target_mode | input | 2 | Number of branch-target bytes to send |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block can accept an event |
| ev_kind | input | 1 | 0 = operand, 1 = taken branch |
| ev_write | input | 1 | Operand direction, 1 = write |
| ev_size | input | 2 | Operand access size |
| ev_data | input | 32 | Operand data or branch target |
| trc_valid | output | 1 | Nibble present this cycle |
| trc_nibble | output | 4 | Trace nibble |

## Verification
The hardest case to reach from the ports is an event that is already waiting while a stream is in progress, especially when the control fields change under it. The stimulus sets this up directly. It keeps `ev_valid` high after an acceptance, swaps in a second payload and clears `capture_mode` in the same cycle. It then checks that the first stream still runs to full length and that the waiting event is taken only in the cycle after the last nibble. A sweep over every combination of kind, direction, size and the two control fields covers all the length encodings, and a reset issued partway through a long stream covers dropping a partly sent event.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic {
    EV_OPERAND = 1'b0,
    EV_BRANCH  = 1'b1
  } ev_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } op_size_e;
endpackage

// File: rtl/trc_len_decode.sv
module trc_len_decode #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic             kind,
  input  logic             write,
  input  logic [1:0]       size,
  input  logic [1:0]       cap_mode,
  input  logic [1:0]       tgt_mode,
  output logic [CNT_W-1:0] len
);
  import trc_pkg::*;

  localparam int NIBS_PER_BYTE = 8 / NIB_W;
  localparam int NIBS_MAX      = DATA_W / NIB_W;
  localparam logic [CNT_W-1:0] L_BYTE  = CNT_W'(NIBS_PER_BYTE);
  localparam logic [CNT_W-1:0] L_WORD  = CNT_W'(2 * NIBS_PER_BYTE);
  localparam logic [CNT_W-1:0] L_TGT3  = CNT_W'(3 * NIBS_PER_BYTE);
  localparam logic [CNT_W-1:0] L_FULL  = CNT_W'(NIBS_MAX);

  logic captured;

  // Direction filter: bit 0 enables writes, bit 1 enables reads.
  always_comb begin
    captured = write ? cap_mode[0] : cap_mode[1];
  end

  always_comb begin
    len = '0;
    if (ev_kind_e'(kind) == EV_BRANCH) begin
      unique case (tgt_mode)
        2'b01:   len = L_WORD;
        2'b10:   len = L_TGT3;
        2'b11:   len = L_FULL;
        default: len = '0;
      endcase
    end else if (captured) begin
      unique case (op_size_e'(size))
        SZ_BYTE: len = L_BYTE;
        SZ_WORD: len = L_WORD;
        default: len = L_FULL;
      endcase
    end
  end
endmodule

// File: rtl/trc_nibble_shifter.sv
module trc_nibble_shifter #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CNT_W-1:0]  load_len,
  output logic              out_valid,
  output logic [NIB_W-1:0]  out_nibble,
  output logic              busy
);
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      shreg  <= load_data;
      remain <= load_len;
    end else if (remain != '0) begin
      shreg  <= shreg >> NIB_W;
      remain <= remain - 1'b1;
    end
  end

  always_comb begin
    busy       = (remain != '0);
    out_valid  = busy;
    out_nibble = busy ? shreg[NIB_W-1:0] : '0;
  end
endmodule

// File: rtl/trace_nibble_serializer.sv
module trace_nibble_serializer #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        capture_mode,
  input  logic [1:0]        target_mode,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_kind,
  input  logic              ev_write,
  input  logic [1:0]        ev_size,
  input  logic [DATA_W-1:0] ev_data,
  output logic              trc_valid,
  output logic [NIB_W-1:0]  trc_nibble
);
  localparam int NIBS  = DATA_W / NIB_W;
  localparam int CNT_W = $clog2(NIBS + 1);

  logic [CNT_W-1:0] ev_len;
  logic             accept;
  logic             busy;

  trc_len_decode #(.DATA_W(DATA_W), .NIB_W(NIB_W), .CNT_W(CNT_W)) u_dec (
    .kind     (ev_kind),
    .write    (ev_write),
    .size     (ev_size),
    .cap_mode (capture_mode),
    .tgt_mode (target_mode),
    .len      (ev_len)
  );

  always_comb begin
    ev_ready = !busy;
    accept   = ev_valid && ev_ready;
  end

  trc_nibble_shifter #(.DATA_W(DATA_W), .NIB_W(NIB_W), .CNT_W(CNT_W)) u_shf (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_data  (ev_data),
    .load_len   (ev_len),
    .out_valid  (trc_valid),
    .out_nibble (trc_nibble),
    .busy       (busy)
  );
endmodule

// File: rtl/trc_serializer_checker.sv
module trc_serializer_checker #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        capture_mode,
  input logic [1:0]        target_mode,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              ev_kind,
  input logic [DATA_W-1:0] ev_data,
  input logic              trc_valid,
  input logic [NIB_W-1:0]  trc_nibble
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_IDLE: assert (!trc_valid && ev_ready); // R8
    end
  end

  AST_STREAM_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    trc_valid |-> !ev_ready); // R6

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(trc_valid) |-> ev_ready); // R6

  AST_IDLE_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !trc_valid |-> (trc_nibble == '0)); // R7

  AST_CAPTURE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && !ev_kind && capture_mode == 2'b00) |=> !trc_valid); // R1

  AST_BRANCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind && target_mode == 2'b00) |=> (!trc_valid && ev_ready)); // R3

  AST_BRANCH_FIRST_NIB: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind && target_mode != 2'b00)
      |=> (trc_valid && trc_nibble == $past(ev_data[NIB_W-1:0]))); // R5
endmodule

bind trace_nibble_serializer trc_serializer_checker #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .capture_mode (capture_mode),
  .target_mode  (target_mode),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .ev_kind      (ev_kind),
  .ev_data      (ev_data),
  .trc_valid    (trc_valid),
  .trc_nibble   (trc_nibble)
);

// File: tb/trace_nibble_serializer_bench.sv
module trace_nibble_serializer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  capture_mode, target_mode, ev_size;
  logic        ev_valid, ev_kind, ev_write;
  logic [31:0] ev_data;
  logic        ev_ready, trc_valid;
  logic [3:0]  trc_nibble;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  trace_nibble_serializer u_trace_nibble_serializer (
    .clk(clk), .rst(rst), .capture_mode(capture_mode), .target_mode(target_mode),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_write(ev_write),
    .ev_size(ev_size), .ev_data(ev_data), .trc_valid(trc_valid), .trc_nibble(trc_nibble)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_nibs(bit kind, bit wr, logic [1:0] size, logic [1:0] cap, logic [1:0] tgt);
    if (kind) return (tgt == 2'd0) ? 0 : (tgt == 2'd1) ? 4 : (tgt == 2'd2) ? 6 : 8;
    if (!(wr ? cap[0] : cap[1])) return 0;
    return (size == 2'd0) ? 2 : (size == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [31:0] keep_low(logic [31:0] v, int n);
    return (n >= 8) ? v : (v & ((32'h1 << (4 * n)) - 1));
  endfunction

  // Collect a stream that starts at the current negedge; returns count and value.
  task automatic collect(input string req, output int n, output logic [31:0] val);
    n = 0; val = '0;
    while (trc_valid && n < 12) begin
      check(!ev_ready, "R6 ready low in stream", 32'(ev_ready), 32'h0);
      val = val | (32'(trc_nibble) << (4 * n));
      n++;
      @(negedge clk);
    end
    check(ev_ready && trc_nibble == 4'h0, {req, " R7 idle after stream"},
          {27'h0, ev_ready, trc_nibble}, 32'h10);
  endtask

  task automatic run_event(input bit kind, input bit wr, input logic [1:0] size,
                           input logic [1:0] cap, input logic [1:0] tgt, input logic [31:0] data);
    int n; logic [31:0] val; int en;
    en = exp_nibs(kind, wr, size, cap, tgt);
    ev_kind = kind; ev_write = wr; ev_size = size; capture_mode = cap; target_mode = tgt;
    ev_data = data; ev_valid = 1'b1;
    check(ev_ready, "R6 ready before offer", 32'(ev_ready), 32'h1);
    @(negedge clk);
    ev_valid = 1'b0;
    collect(kind ? "R4" : "R1/R2", n, val);
    check(n == en, kind ? "R4 branch nibble count" : (en == 0 ? "R3 filtered count" : "R2 operand nibble count"),
          32'(n), 32'(en));
    check(val == keep_low(data, en), "R5 nibble order/value", val, keep_low(data, en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n; logic [31:0] val; int idx;
    rst = 1'b1; ev_valid = 1'b0; ev_kind = 1'b0; ev_write = 1'b0; ev_size = 2'd0;
    ev_data = '0; capture_mode = 2'd0; target_mode = 2'd0;
    repeat (3) @(negedge clk);
    check(!trc_valid && ev_ready && trc_nibble == 4'h0, "R8 reset state",
          {27'h0, trc_valid, ev_ready, 3'h0}, 32'h08);
    rst = 1'b0;
    @(negedge clk);

    // Sweep every operand combination (R1, R2, R3)
    idx = 0;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++) begin
          run_event(1'b0, w[0], s[1:0], c[1:0], 2'd0, 32'h9E3779B9 * (idx + 1) ^ 32'h5A5A_0F0F);
          idx++;
        end
    // Sweep branch target widths (R4), with capture mode irrelevant
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 4; c++)
        run_event(1'b1, c[0], 2'd3, c[1:0], t[1:0], 32'hC3A5_1E87 + 32'(t * 32'h0111_1111 + c));

    // R6 + R9: event held valid across a stream, controls changed under it
    ev_kind = 1'b0; ev_write = 1'b1; ev_size = 2'd2; capture_mode = 2'b01;
    ev_data = 32'h8765_4321; ev_valid = 1'b1;
    @(negedge clk);
    ev_data = 32'hFEDC_BA98; capture_mode = 2'b00;  // waiting event, now filtered
    collect("R9", n, val);
    check(n == 8 && val == 32'h8765_4321, "R9 stream unchanged by control change", val, 32'h8765_4321);
    // Ready is high now: held event is accepted here and is filtered
    @(negedge clk);
    ev_valid = 1'b0;
    check(!trc_valid && ev_ready, "R6 waiting event taken after last, R3 filtered",
          {30'h0, trc_valid, ev_ready}, 32'h1);
    // Held event with capture on: second stream follows after one gap cycle
    capture_mode = 2'b11; ev_write = 1'b0; ev_size = 2'd1; ev_data = 32'h0000_ABCD; ev_valid = 1'b1;
    @(negedge clk);
    ev_data = 32'h0000_1357;
    collect("R6", n, val);
    check(n == 4 && val == 32'h0000_ABCD, "R6 first of back-to-back", val, 32'h0000_ABCD);
    @(negedge clk);
    ev_valid = 1'b0;
    collect("R6", n, val);
    check(n == 4 && val == 32'h0000_1357, "R6 second of back-to-back", val, 32'h0000_1357);

    // R8: reset in the middle of a long stream
    ev_kind = 1'b1; target_mode = 2'b11; ev_data = 32'h2468_ACE0; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(trc_valid, "R8 stream running before reset", 32'(trc_valid), 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!trc_valid && ev_ready && trc_nibble == 4'h0, "R8 partial event dropped",
          {27'h0, trc_valid, ev_ready, 3'h0}, 32'h08);
    @(negedge clk);
    check(!trc_valid, "R8 no resumed nibbles", 32'(trc_valid), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule